// File: doc/BRIEF.md
# Exponential argument index extractor

This block sits in the range-reduction stage of a table-driven exponential unit. Its input is a single-precision value that already equals x·32/ln2. It rounds that value to the nearest integer N, with ties rounded away from zero. It then splits N into a non-negative table index j = N mod 32 and an exponent m = (N − j)/32.

Four results come out of one output register. N is given as a float. j is given both as a float and as a 5-bit unsigned index for the table lookup. The fourth result is the scale factor 2^m as a float. The multiply by 32/ln2, the table, the polynomial and the final scaling belong to neighbouring blocks.

Inputs too large to carry a fraction are passed through as N. Their index comes from the low integer bits, and their scale saturates. Scale values outside the normal exponent range also saturate, to +0 or +infinity.

Top module: `exp_index_split`

## Requirements
- R1: An input with biased exponent below 126 (|x| < 0.5, including ±0 and subnormals) gives N = 0x00000000, index 0, j float 0x00000000 and scale 1.0 (0x3F800000).
- R2: An input with biased exponent 126 (0.5 ≤ |x| < 1) gives N = ±1.0 (0x3F800000 or 0xBF800000) carrying the input sign.
- R3: For 1 ≤ |x| < 2^23, N is x rounded to the nearest integer. A tie goes away from zero: the fraction is dropped and the magnitude is raised by one when the 0.5 bit is set. N is output as the exact float of that integer.
- R4: The index output (5 bits, unsigned) equals N mod 32 and lies in 0..31, also for negative N: for example N = −1 gives 31.
- R5: The j float output is the exact float of the index. Index 0 is encoded as 0x00000000.
- R6: The scale output is 2^m with m = (N − j)/32: sign 0, fraction field 0, exponent field m + 127.
- R7: When m > 127 the scale is +infinity (0x7F800000). When m < −126 the scale is +0 (0x00000000).
- R8: An input with biased exponent 150 or more (|x| ≥ 2^23, and also infinities and NaN) is output unchanged as N. The index is taken as in R4 from the low five integer bits of that integer, and is 0 when the exponent is 155 or more. The scale is +infinity for a positive sign and +0 for a negative sign.
- R9: All outputs are registered and reflect the input of the previous rising clock edge. A synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 32 | Single-precision value x·32/ln2 |
| n_out | output | 32 | Rounded integer N as a float |
| j_out | output | 32 | Table index j as a float |
| j_idx | output | 5 | Table index j, unsigned |
| scale_out | output | 32 | Scale factor 2^m as a float |

## Verification
Each of the four results is due exactly one rising edge after the input is presented. The bench drives each input on a falling edge and compares all four outputs at the next falling edge, so exactly one register stage lies between stimulus and sample. The reset values are compared while reset is held, with a non-zero input applied. The bulk sweep steps through every multiple of 0.25 in ±5000, which covers ties and both scale saturations. Fixed vectors cover the tiny, half-unit and large-magnitude branches.

// File: rtl/exi_pkg.sv
package exi_pkg;
  localparam int EXI_EXP_W  = 8;
  localparam int EXI_FRAC_W = 23;
  localparam int EXI_IDX_W  = 5;
endpackage

// File: rtl/exi_round.sv
module exi_round #(
  parameter int EXP_W  = exi_pkg::EXI_EXP_W,
  parameter int FRAC_W = exi_pkg::EXI_FRAC_W,
  parameter int IDX_W  = exi_pkg::EXI_IDX_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int MAG_W = SIG_W + 1
) (
  input  logic [W-1:0]     x,
  output logic [MAG_W-1:0] mag,
  output logic             neg,
  output logic             big,
  output logic [IDX_W-1:0] big_low
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] t;
  int               e_i;
  int               t_sh;
  int               l_sh;

  always_comb begin
    sig     = {1'b1, x[FRAC_W-1:0]};
    e_i     = int'(x[W-2:FRAC_W]);
    t_sh    = BIAS + FRAC_W - 1 - e_i;
    l_sh    = e_i - BIAS - FRAC_W;
    t       = '0;
    mag     = '0;
    big     = 1'b0;
    big_low = '0;
    if (e_i < BIAS - 1) begin
      mag = '0;
    end else if (e_i == BIAS - 1) begin
      mag = MAG_W'(1);
    end else if (e_i < BIAS + FRAC_W) begin
      // keep one bit below the binary point, then round on it
      t   = sig >> t_sh;
      mag = MAG_W'(t[SIG_W-1:1]) + MAG_W'(t[0]);
    end else begin
      big = 1'b1;
      if (l_sh < IDX_W) big_low = IDX_W'(sig << l_sh);
    end
    neg = x[W-1] & (big | (mag != '0));
  end
endmodule

// File: rtl/exi_split.sv
module exi_split #(
  parameter int FRAC_W = exi_pkg::EXI_FRAC_W,
  parameter int IDX_W  = exi_pkg::EXI_IDX_W,
  localparam int MAG_W = FRAC_W + 2,
  localparam int M_W   = MAG_W + 1 - IDX_W
) (
  input  logic [MAG_W-1:0]      mag,
  input  logic                  neg,
  input  logic                  big,
  input  logic [IDX_W-1:0]      big_low,
  output logic [IDX_W-1:0]      j,
  output logic signed [M_W-1:0] m
);
  logic [IDX_W-1:0]      low;
  logic signed [MAG_W:0] n_s;

  always_comb begin
    low = big ? big_low : mag[IDX_W-1:0];
    // modulo of a negative value wraps back into 0..2^IDX_W-1
    j   = neg ? (~low + 1'b1) : low;
    n_s = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    // arithmetic shift is the floor division, equal to (N - j) / 2^IDX_W
    m   = M_W'(n_s >>> IDX_W);
  end
endmodule

// File: rtl/exi_pow2.sv
module exi_pow2 #(
  parameter int EXP_W  = exi_pkg::EXI_EXP_W,
  parameter int FRAC_W = exi_pkg::EXI_FRAC_W,
  parameter int M_W    = FRAC_W + 3 - exi_pkg::EXI_IDX_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic signed [M_W-1:0] m,
  input  logic                  big,
  input  logic                  neg,
  output logic [W-1:0]          scale
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  int mi;

  always_comb begin
    mi = int'(m);
    if (big)                scale = neg ? '0 : POS_INF;
    else if (mi > BIAS)     scale = POS_INF;
    else if (mi < 1 - BIAS) scale = '0;
    else                    scale = {1'b0, EXP_W'(mi + BIAS), {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/exi_i2f.sv
module exi_i2f #(
  parameter int IN_W   = exi_pkg::EXI_IDX_W,
  parameter int EXP_W  = exi_pkg::EXI_EXP_W,
  parameter int FRAC_W = exi_pkg::EXI_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [IN_W-1:0] mag,
  input  logic            neg,
  output logic [W-1:0]    f
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  int p;

  always_comb begin
    p = 0;
    for (int i = 0; i < IN_W; i++) begin
      if (mag[i]) p = i;
    end
    if (mag == '0) f = '0;
    else f = {neg, EXP_W'(BIAS + p), FRAC_W'({mag, {FRAC_W{1'b0}}} >> p)};
  end
endmodule

// File: rtl/exp_index_split.sv
module exp_index_split #(
  parameter int EXP_W  = exi_pkg::EXI_EXP_W,
  parameter int FRAC_W = exi_pkg::EXI_FRAC_W,
  parameter int IDX_W  = exi_pkg::EXI_IDX_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = FRAC_W + 2,
  localparam int M_W   = MAG_W + 1 - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     x_in,
  output logic [W-1:0]     n_out,
  output logic [W-1:0]     j_out,
  output logic [IDX_W-1:0] j_idx,
  output logic [W-1:0]     scale_out
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] ONE_F = {1'b0, EXP_W'(BIAS), {FRAC_W{1'b0}}};

  logic [MAG_W-1:0]      mag;
  logic                  neg;
  logic                  big;
  logic [IDX_W-1:0]      big_low;
  logic [IDX_W-1:0]      j;
  logic signed [M_W-1:0] m;
  logic [W-1:0]          n_f;
  logic [W-1:0]          j_f;
  logic [W-1:0]          sc_f;

  exi_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_round (
    .x(x_in), .mag(mag), .neg(neg), .big(big), .big_low(big_low));

  exi_split #(.FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_split (
    .mag(mag), .neg(neg), .big(big), .big_low(big_low), .j(j), .m(m));

  exi_pow2 #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .M_W(M_W)) u_pow2 (
    .m(m), .big(big), .neg(neg), .scale(sc_f));

  exi_i2f #(.IN_W(MAG_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_n2f (
    .mag(mag), .neg(neg), .f(n_f));

  exi_i2f #(.IN_W(IDX_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_j2f (
    .mag(j), .neg(1'b0), .f(j_f));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_out     <= '0;
      j_out     <= '0;
      j_idx     <= '0;
      scale_out <= '0;
    end else begin
      n_out     <= big ? x_in : n_f;
      j_out     <= j_f;
      j_idx     <= j;
      scale_out <= sc_f;
    end
  end

  AST_TINY_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (x_in[W-2:FRAC_W] < EXP_W'(BIAS - 1)) |=>
      (n_out == '0 && j_idx == '0 && scale_out == ONE_F)); // R1

  AST_HALF_UNIT: assert property (@(posedge clk) disable iff (rst)
    (x_in[W-2:FRAC_W] == EXP_W'(BIAS - 1)) |=>
      (n_out == {$past(x_in[W-1]), EXP_W'(BIAS), {FRAC_W{1'b0}}})); // R2

  AST_LARGE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (x_in[W-2:FRAC_W] >= EXP_W'(BIAS + FRAC_W)) |=> (n_out == $past(x_in))); // R8

  AST_SCALE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (scale_out[W-1] == 1'b0 && scale_out[FRAC_W-1:0] == '0)); // R6

  AST_IDX_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((j_idx == '0) == (j_out == '0))); // R5
endmodule

// File: tb/test_exp_index_split.sv
`timescale 1ns/1ps
module test_exp_index_split;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] x_in = '0;
  logic [31:0] n_out, j_out, scale_out;
  logic [4:0]  j_idx;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  exp_index_split i_exp_index_split (
    .clk(clk), .rst(rst), .x_in(x_in), .n_out(n_out), .j_out(j_out),
    .j_idx(j_idx), .scale_out(scale_out));

  function automatic logic [31:0] int_to_f(int v);
    int a;
    int p;
    if (v == 0) return 32'h0;
    a = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 31; i++) if ((a >> i) & 1) p = i;
    return {(v < 0), 8'(127 + p), 23'(a << (23 - p))};
  endfunction

  function automatic logic [31:0] scale_of(int mm);
    if (mm > 127) return 32'h7F800000;
    if (mm < -126) return 32'h0;
    return {1'b0, 8'(mm + 127), 23'h0};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] en,
                       input int ej, input logic [31:0] es, input string rn,
                       input string rs);
    logic bad;
    @(negedge clk);
    x_in = x;
    @(negedge clk);
    bad = 1'b0;
    n_vec++;
    if (n_out !== en) begin
      bad = 1'b1;
      $display("FAIL %s N x=%h got %h exp %h", rn, x, n_out, en);
    end
    if (j_idx !== 5'(ej)) begin
      bad = 1'b1;
      $display("FAIL R4 index x=%h got %0d exp %0d", x, j_idx, ej);
    end
    if (j_out !== int_to_f(ej)) begin
      bad = 1'b1;
      $display("FAIL R5 j float x=%h got %h exp %h", x, j_out, int_to_f(ej));
    end
    if (scale_out !== es) begin
      bad = 1'b1;
      $display("FAIL %s scale x=%h got %h exp %h", rs, x, scale_out, es);
    end
    if (bad) n_bad++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R9: reset clears every output even with a live input
    x_in = 32'h40400000;
    repeat (3) @(negedge clk);
    n_vec++;
    if ({n_out, j_out, j_idx, scale_out} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset got %h %h %h %h exp all zero",
               n_out, j_out, j_idx, scale_out);
    end
    rst = 1'b0;

    // R1 tiny inputs
    apply(32'h00000000, 32'h0, 0, 32'h3F800000, "R1", "R1");
    apply(32'h80000000, 32'h0, 0, 32'h3F800000, "R1", "R1");
    apply(32'h00000001, 32'h0, 0, 32'h3F800000, "R1", "R1");
    apply(32'h3EFFFFFF, 32'h0, 0, 32'h3F800000, "R1", "R1");
    // R2 half-unit band
    apply(32'h3F000000, 32'h3F800000, 1, 32'h3F800000, "R2", "R6");
    apply(32'hBF400000, 32'hBF800000, 31, 32'h3F000000, "R2", "R6");
    // R3 carry into 2^23
    apply(32'h4AFFFFFF, 32'h4B000000, 0, 32'h7F800000, "R3", "R7");
    // R8 large magnitudes and non-finite values
    apply(32'h4B000001, 32'h4B000001, 1, 32'h7F800000, "R8", "R8");
    apply(32'hCB000003, 32'hCB000003, 29, 32'h00000000, "R8", "R8");
    apply(32'h4C000001, 32'h4C000001, 4, 32'h7F800000, "R8", "R8");
    apply(32'h7FC00000, 32'h7FC00000, 0, 32'h7F800000, "R8", "R8");
    apply(32'hFF800000, 32'hFF800000, 0, 32'h00000000, "R8", "R8");

    // sweep x = a/4 over +-5000: rounding, wrap, scale and saturation
    for (int a = -20000; a <= 20000; a++) begin
      logic [31:0] xf;
      int mg, nn, jj, mm;
      string rn, rs;
      xf = int_to_f(a);
      if (a != 0) xf[30:23] = xf[30:23] - 8'd2;
      mg = ((a < 0 ? -a : a) + 2) / 4;
      nn = (a < 0) ? -mg : mg;
      jj = ((nn % 32) + 32) % 32;
      mm = (nn - jj) / 32;
      rn = (a > -2 && a < 2) ? "R1" : ((a > -4 && a < 4) ? "R2" : "R3");
      rs = (mm > 127 || mm < -126) ? "R7" : "R6";
      apply(xf, int_to_f(nn), jj, scale_of(mm), rn, rs);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule